// File: doc/BRIEF.md
# Vector Load/Store Address Sequencer

This block turns one vector memory instruction into a stream of per-element effective addresses. At start it captures a scalar base value, a flag that forces the base to zero, a signed 16-bit displacement and an element count. It then issues one address per cycle over a valid/ready handshake, and each address carries its element index. The update forms also produce the final base value that is written back to the register file.

There are three addressing flavours. Strided addressing places element i at base + disp*i and never writes the base back. Pre-advance update moves the base forward by the displacement before each access, so every access uses the moved value. Post-increment uses the current base for the access and moves it forward afterwards. Both update flavours write back base + count*disp. The multiply is avoided with a running base register that adds the sign-extended displacement once per accepted element.

Top module: `vls_addr_seq`

## Requirements
- R1: After reset, addr_valid_o, done_o and wb_en_o are all low.
- R2: With mode_i = 0 (strided), element i (0 to VL-1) is issued with addr_o = B + S*i and elem_idx_o = i. B is the start base and S the sign-extended displacement. wb_en_o stays low.
- R3: With mode_i = 2 (post-increment), element i uses addr_o = B + S*i. At the end, wb_val_o = B + VL*S is written back with wb_en_o high.
- R4: With mode_i = 1 (pre-advance update), element i uses addr_o = B + S*(i+1). At the end, wb_val_o = B + VL*S is written back with wb_en_o high.
- R5: When base_zero_i is high at start, B is zero whatever base_i holds.
- R6: disp_i is a 16-bit two's-complement value, sign-extended to 64 bits. All address arithmetic wraps modulo 2^64.
- R7: While addr_valid_o is high and addr_ready_i is low, addr_o and elem_idx_o hold their values. With ready held high, one element is accepted every cycle.
- R8: done_o pulses for exactly one cycle, in the cycle after the last element is accepted. wb_en_o is high only in that cycle, and only for modes 1 and 2.
- R9: With vl_i = 0, no address is issued and no writeback occurs. done_o pulses in the cycle after start.
- R10: Operands are captured on the start cycle. Later changes to the operand inputs, and any start pulse while a sequence is active, have no effect.
- R11: mode_i = 3 behaves exactly like strided mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| mode_i | input | 2 | Addressing mode (0 strided, 1 pre-advance update, 2 post-increment, 3 strided) |
| base_i | input | ADDR_W | Scalar base register value |
| base_zero_i | input | 1 | Base field names register zero; use a literal zero |
| disp_i | input | DISP_W | Signed displacement |
| vl_i | input | VL_W | Element count |
| addr_ready_i | input | 1 | Consumer accepts the current address |
| addr_valid_o | output | 1 | Address valid |
| addr_o | output | ADDR_W | Effective address of the current element |
| elem_idx_o | output | VL_W | Index of the current element |
| wb_en_o | output | 1 | Base writeback enable |
| wb_val_o | output | ADDR_W | Base value to write back |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The checker takes addr_ready_i and start_i to be clean 0/1 levels in every cycle. It also treats an address held for a consumer that is not ready as the only legal stall behaviour. It does not assume the operand inputs stay stable after start, because the design captures them. The stimulus drives every input at the falling edge and keeps all inputs defined. It deliberately corrupts the operand inputs, and pulses start again, while a sequence runs, so capture is exercised without breaking those assumptions. Ready follows fixed per-test patterns, which produce both back-to-back acceptances and multi-cycle stalls.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [1:0] {
    MODE_STRIDE     = 2'd0,
    MODE_UPDATE     = 2'd1,
    MODE_POSTINC    = 2'd2,
    MODE_STRIDE_ALT = 2'd3
  } agen_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vls_operand.sv
module vls_operand #(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic              base_zero_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] base_eff_o,
  output logic [ADDR_W-1:0] stride_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  assign base_eff_o = base_zero_i ? '0 : base_i;
  assign stride_o   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      mode_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            ready_i,
  output logic            load_o,
  output logic            step_o,
  output logic            valid_o,
  output logic [VL_W-1:0] idx_o,
  output logic            pre_adv_o,
  output logic            done_o,
  output logic            wb_en_o
);
  localparam logic [VL_W-1:0] ONE = {{(VL_W-1){1'b0}}, 1'b1};

  seq_state_e      state_q, state_d;
  logic [VL_W-1:0] vl_q, idx_q;
  agen_mode_e      mode_q;
  logic            last;

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign valid_o = (state_q == ST_RUN);
  assign step_o  = valid_o && ready_i;
  assign last    = (idx_q == vl_q - ONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = (vl_i == '0) ? ST_FIN : ST_RUN;
      ST_RUN:  if (step_o && last) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      idx_q   <= '0;
      mode_q  <= MODE_STRIDE;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        vl_q   <= vl_i;
        idx_q  <= '0;
        mode_q <= agen_mode_e'(mode_i);
      end else if (step_o && !last) begin
        idx_q <= idx_q + ONE;
      end
    end
  end

  assign idx_o     = idx_q;
  assign pre_adv_o = (mode_q == MODE_UPDATE);
  assign done_o    = (state_q == ST_FIN);
  // zero-length sequences never write the base
  assign wb_en_o   = done_o && (vl_q != '0) &&
                     ((mode_q == MODE_UPDATE) || (mode_q == MODE_POSTINC));
endmodule

// File: rtl/vls_acc.sv
module vls_acc #(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              pre_adv_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-1:0] base_q, stride_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      stride_q <= '0;
    end else if (load_i) begin
      base_q   <= base_i;
      stride_q <= stride_i;
    end else if (step_i) begin
      base_q <= base_q + stride_q;
    end
  end

  // base_q always holds B + S*accepted; pre-advance reads one step ahead
  assign addr_o = pre_adv_i ? base_q + stride_q : base_q;
  assign base_o = base_q;
endmodule

// File: rtl/vls_addr_seq.sv
module vls_addr_seq #(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int VL_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              base_zero_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic              addr_ready_i,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [VL_W-1:0]   elem_idx_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_val_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] base_eff, stride;
  logic              load, step, pre_adv;

  vls_operand #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_operand (
    .base_i      (base_i),
    .base_zero_i (base_zero_i),
    .disp_i      (disp_i),
    .base_eff_o  (base_eff),
    .stride_o    (stride)
  );

  vls_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .vl_i      (vl_i),
    .ready_i   (addr_ready_i),
    .load_o    (load),
    .step_o    (step),
    .valid_o   (addr_valid_o),
    .idx_o     (elem_idx_o),
    .pre_adv_o (pre_adv),
    .done_o    (done_o),
    .wb_en_o   (wb_en_o)
  );

  vls_acc #(.ADDR_W(ADDR_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .pre_adv_i (pre_adv),
    .base_i    (base_eff),
    .stride_i  (stride),
    .addr_o    (addr_o),
    .base_o    (wb_val_o)
  );
endmodule

// File: rtl/vls_addr_seq_chk.sv
module vls_addr_seq_chk #(
  parameter int ADDR_W = 64,
  parameter int VL_W   = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_ready_i,
  input logic              addr_valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [VL_W-1:0]   elem_idx_o,
  input logic              wb_en_o,
  input logic              done_o
);
  localparam logic [VL_W-1:0] ONE = {{(VL_W-1){1'b0}}, 1'b1};

  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o) && $stable(elem_idx_o));

  a_r7_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && addr_ready_i |=> !addr_valid_o || (elem_idx_o == $past(elem_idx_o) + ONE));

  a_r2_first_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_valid_o) |-> elem_idx_o == '0);

  a_r8_wb_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({addr_valid_o, done_o}));
endmodule

bind vls_addr_seq vls_addr_seq_chk #(.ADDR_W(ADDR_W), .VL_W(VL_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_ready_i (addr_ready_i),
  .addr_valid_o (addr_valid_o),
  .addr_o       (addr_o),
  .elem_idx_o   (elem_idx_o),
  .wb_en_o      (wb_en_o),
  .done_o       (done_o)
);

// File: tb/vls_addr_seq_tb_top.sv
module vls_addr_seq_tb_top;
  localparam int ADDR_W = 64;
  localparam int DISP_W = 16;
  localparam int VL_W   = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [1:0]        mode_i = '0;
  logic [ADDR_W-1:0] base_i = '0;
  logic              base_zero_i = 1'b0;
  logic [DISP_W-1:0] disp_i = '0;
  logic [VL_W-1:0]   vl_i = '0;
  logic              addr_ready_i = 1'b0;
  logic              addr_valid_o, wb_en_o, done_o;
  logic [ADDR_W-1:0] addr_o, wb_val_o;
  logic [VL_W-1:0]   elem_idx_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  vls_addr_seq #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .VL_W(VL_W)) dut_i (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 valid", 64'(addr_valid_o), 64'd0);
    chk("R1 done", 64'(done_o), 64'd0);
    chk("R1 wb_en", 64'(wb_en_o), 64'd0);
  endtask

  task automatic run_seq(logic [1:0] mode, logic [63:0] base, bit bz,
                         logic [15:0] disp, int vl, logic [7:0] rdy_pat);
    logic [63:0] b, s, held_a;
    logic [VL_W-1:0] held_i;
    int k = 0, cyc = 0, last_fire = -1;
    bit stalled = 0, seen_done = 0;
    bit upd = (mode == 2'd1);
    bit wb  = (mode == 2'd1) || (mode == 2'd2);
    string rq = (mode == 2'd1) ? "R4" : (mode == 2'd2) ? "R3" : (mode == 2'd3) ? "R11" : "R2";
    b = bz ? 64'd0 : base;
    s = {{48{disp[15]}}, disp};
    @(negedge clk_i);
    start_i = 1'b1; mode_i = mode; base_i = base; base_zero_i = bz;
    disp_i = disp; vl_i = VL_W'(vl); addr_ready_i = 1'b0;
    @(negedge clk_i);
    // R10: corrupt operands after capture
    start_i = 1'b0; base_i = ~base; base_zero_i = ~bz; disp_i = ~disp;
    mode_i = ~mode; vl_i = ~vl_i;
    while (!seen_done && cyc < 1000) begin
      addr_ready_i = rdy_pat[cyc % 8];
      start_i = (cyc == 2 && vl >= 4); // R10: restart attempt while busy
      #1;
      if (stalled && addr_valid_o) begin
        chk("R7 held addr", addr_o, held_a);
        chk("R7 held idx", 64'(elem_idx_o), 64'(held_i));
      end
      if (done_o) begin
        seen_done = 1;
        chk({rq, " count"}, 64'(k), 64'(vl));
        if (vl == 0) chk("R9 done timing", 64'(cyc), 64'd0);
        else chk("R8 done timing", 64'(cyc), 64'(last_fire + 1));
        chk("R8 wb_en", 64'(wb_en_o), 64'((vl != 0) && wb));
        if (wb && vl != 0) chk({rq, " wb_val"}, wb_val_o, b + s * 64'(vl));
      end else if (addr_valid_o) begin
        chk({rq, " addr"}, addr_o, b + s * 64'(k + int'(upd)));
        chk({rq, " idx"}, 64'(elem_idx_o), 64'(k));
        if (addr_ready_i) begin k++; last_fire = cyc; end
        stalled = !addr_ready_i; held_a = addr_o; held_i = elem_idx_o;
      end
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0; addr_ready_i = 1'b0;
    if (!seen_done) chk("R8 done seen", 64'd0, 64'd1);
    #1;
    chk("R8 done one cycle", 64'(done_o), 64'd0);
    chk("R8 wb_en one cycle", 64'(wb_en_o), 64'd0);
    chk("R10 idle after end", 64'(addr_valid_o), 64'd0);
  endtask

  initial begin
    #15 rst_ni = 1'b1;
    fork
      begin
        @(negedge clk_i);
        t_reset();                                             // R1
        run_seq(2'd2, 64'd16, 0, 16'd24, 2, 8'hFF);            // R3 post-increment example
        run_seq(2'd0, 64'h100, 0, 16'd8, 5, 8'b1011_0101);     // R2 with stalls (R7)
        run_seq(2'd1, 64'h1000, 0, 16'hFFF0, 4, 8'hFF);        // R4, negative disp (R6), R10
        run_seq(2'd1, 64'hDEAD_BEEF, 1, 16'd12, 3, 8'b0110_1101); // R5
        run_seq(2'd2, 64'hFFFF_FFFF_FFFF_FFF0, 0, 16'h0010, 4, 8'hFF); // R6 wrap
        run_seq(2'd2, 64'h40, 0, 16'd4, 0, 8'hFF);             // R9
        run_seq(2'd1, 64'h40, 0, 16'd4, 0, 8'hFF);             // R9 update, no writeback
        run_seq(2'd3, 64'h200, 0, 16'd32, 5, 8'b1101_1011);    // R11
        run_seq(2'd0, 64'h8000, 0, 16'h8000, 127, 8'b0110_1011); // R7 long, R6 min disp
        run_seq(2'd2, 64'h10, 0, 16'h7FFF, 6, 8'b0001_0001);   // R3 long stalls
      end
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule